// File: doc/BRIEF.md
# Prefetch-Acquire Merge Controller

This block sits at the entry of a cache slice's request buffer. In the same cycle an upstream request is presented, it compares the request against every outstanding miss entry. It then decides whether the request merges into an entry, is allocated a new entry, or is held in the buffer.

A demand Acquire can arrive while a prefetch miss for the same line is still waiting for data. The block folds that Acquire into the prefetch entry, records the Acquire's requester, and marks the entry as merged. When the lower level later wakes the entry with returned data, a small response sequencer answers both parts in turn. It first issues a prefetch response, and for a merged entry it then issues a grant with data to the stored requester. The grant is accompanied by a training pulse for the prefetcher.

The response sequencer has three states:
- `ST_IDLE`: waiting for a wake-up.
- `ST_PF_RSP`: prefetch response.
- `ST_GRANT`: grant to the merged requester.

Its transitions are:
- `ST_IDLE` to `ST_PF_RSP` on an accepted wake-up.
- `ST_PF_RSP` to `ST_GRANT` when the woken entry is merged.
- `ST_PF_RSP` to `ST_IDLE` when it is not merged.
- `ST_GRANT` to `ST_IDLE` always.

Top module: `mrg_ctrl`

## Requirements
- R1: A request merges (act_o = 1) only when its opcode is the Acquire code 3'd6 and a valid entry holds a prefetch miss, is not already merged, is not being answered, and has the same address. Merge takes precedence over every other action.
- R2: The decision is combinational in the presentation cycle, and hit_vec_o has exactly the matching entry's bit set on a merge and is zero otherwise. act_o encoding: 0 no request, 1 merge, 2 allocate, 3 hold.
- R3: After a merge, the entry counts as merged, and a second Acquire to the same address is held (act_o = 3).
- R4: A request that does not merge but matches the address of any valid entry is held (act_o = 3).
- R5: A request with no address match is allocated (act_o = 2) only when a free entry exists and fewer than N-1 entries hold demand work (a non-prefetch entry or a merged entry). Otherwise it is held.
- R6: A wake-up for a merged entry yields a prefetch response (rsp_kind_o = 1) one cycle after the wake-up edge. This is followed in the next cycle by a grant (rsp_kind_o = 2) carrying the entry number and the merged Acquire's source.
- R7: A wake-up for an unmerged entry yields only the prefetch response, and rsp_valid_o is low in the following cycle.
- R8: train_valid_o pulses together with the grant and names the same entry.
- R9: After the grant, the entry's merged mark is cleared, so a later Acquire to that prefetch entry merges again.
- R10: After reset, rsp_valid_o and train_valid_o are low, wake_ready_o is high, and no entry is merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Request presented |
| req_opcode_i | input | 3 | Request opcode (3'd6 = Acquire) |
| req_addr_i | input | AW | Request line address |
| req_source_i | input | SW | Requester ID |
| ent_valid_i | input | N | Miss entry in use |
| ent_pf_i | input | N | Miss entry holds a prefetch |
| ent_addr_i | input | N*AW | Entry addresses, entry i in bits [i*AW +: AW] |
| wake_valid_i | input | 1 | Data returned for an entry |
| wake_id_i | input | IW | Entry that was woken |
| wake_ready_o | output | 1 | Sequencer idle, wake-up accepted |
| act_o | output | 2 | Decision for the presented request |
| hit_vec_o | output | N | One-hot merge target |
| rsp_valid_o | output | 1 | Response valid |
| rsp_kind_o | output | 2 | 1 prefetch response, 2 grant with data |
| rsp_entry_o | output | IW | Entry being answered |
| rsp_source_o | output | SW | Grant destination (0 for prefetch response) |
| train_valid_o | output | 1 | Prefetcher training pulse |
| train_entry_o | output | IW | Entry for training |

## Verification
The assertions assume that no two valid entries share an address. Without that, the merge hit vector could not be one-hot. They also assume that wake_valid_i is raised only while wake_ready_o is high, and that it names a valid entry. The bench gives every entry a distinct address. It raises a wake-up only while the sequencer is idle, waits for the response sequence to finish before the next wake-up, and never presents a merge in the same cycle as a wake-up.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
    typedef enum logic [1:0] {ACT_NONE = 2'd0, ACT_MERGE = 2'd1, ACT_ALLOC = 2'd2, ACT_HOLD = 2'd3} act_e;
    typedef enum logic [1:0] {RSP_NONE = 2'd0, RSP_PF = 2'd1, RSP_GRANT = 2'd2} rsp_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_PF_RSP = 2'd1, ST_GRANT = 2'd2} st_e;
    localparam logic [2:0] OPC_ACQUIRE = 3'd6;
endpackage

// File: rtl/mrg_match.sv
module mrg_match
    import mrg_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 16,
    localparam int IW = $clog2(N),
    localparam int CW = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_opcode,
    input  logic [AW-1:0]   req_addr,
    input  logic [N-1:0]    ent_valid,
    input  logic [N-1:0]    ent_pf,
    input  logic [N*AW-1:0] ent_addr,
    input  logic [N-1:0]    merged,
    input  logic [N-1:0]    busy,
    output logic [N-1:0]    merge_hit,
    output logic [IW-1:0]   merge_idx,
    output act_e            act
);
    logic [N-1:0] addr_hit;
    logic [CW-1:0] demand_cnt;
    logic is_acq;

    assign is_acq = (req_opcode == OPC_ACQUIRE);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign addr_hit[i]  = req_valid && ent_valid[i] && (ent_addr[i*AW +: AW] == req_addr);
        assign merge_hit[i] = addr_hit[i] && is_acq && ent_pf[i] && !merged[i] && !busy[i];
    end

    always_comb begin
        demand_cnt = '0;
        merge_idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (ent_valid[i] && (!ent_pf[i] || merged[i])) demand_cnt = demand_cnt + 1'b1;
            if (merge_hit[i]) merge_idx = IW'(i);
        end
    end

    always_comb begin
        if (!req_valid)                                       act = ACT_NONE;
        else if (|merge_hit)                                  act = ACT_MERGE;
        else if (|addr_hit)                                   act = ACT_HOLD;
        else if (!(&ent_valid) && (demand_cnt < CW'(N - 1)))  act = ACT_ALLOC;
        else                                                  act = ACT_HOLD;
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(merge_hit)); // R2
    AST_MERGE_NEEDS_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_MERGE) |-> (req_opcode == OPC_ACQUIRE)); // R1
    AST_ALLOC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_ALLOC) |-> (addr_hit == '0)); // R5
endmodule

// File: rtl/mrg_entry_state.sv
module mrg_entry_state #(
    parameter int N  = 16,
    parameter int SW = 6,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic [SW-1:0] set_src,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    input  logic [IW-1:0] rd_idx,
    output logic [N-1:0]  merged,
    output logic [SW-1:0] rd_src
);
    logic [SW-1:0] src_q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            merged <= '0;
            for (int i = 0; i < N; i++) src_q[i] <= '0;
        end else begin
            if (clr_en) merged[clr_idx] <= 1'b0;
            if (set_en) begin
                merged[set_idx] <= 1'b1;
                src_q[set_idx]  <= set_src;
            end
        end
    end

    assign rd_src = src_q[rd_idx];

    AST_MERGED_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> merged[$past(set_idx)]); // R3
endmodule

// File: rtl/mrg_rsp_fsm.sv
module mrg_rsp_fsm
    import mrg_pkg::*;
#(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wake_valid,
    input  logic [IW-1:0] wake_id,
    input  logic [N-1:0]  merged,
    output logic          wake_ready,
    output rsp_e          rsp_kind,
    output logic [IW-1:0] cur_id,
    output logic [N-1:0]  busy,
    output logic          grant_now
);
    st_e state_q, state_d;
    logic merged_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (wake_valid) state_d = ST_PF_RSP;
            ST_PF_RSP: state_d = merged_q ? ST_GRANT : ST_IDLE;
            ST_GRANT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_id   <= '0;
            merged_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && wake_valid) begin
                cur_id   <= wake_id;
                merged_q <= merged[wake_id];
            end
        end
    end

    always_comb begin
        wake_ready = 1'b0;
        rsp_kind   = RSP_NONE;
        grant_now  = 1'b0;
        busy       = '0;
        unique case (state_q)
            ST_IDLE:   wake_ready = 1'b1;
            ST_PF_RSP: begin rsp_kind = RSP_PF; busy[cur_id] = 1'b1; end
            ST_GRANT:  begin rsp_kind = RSP_GRANT; grant_now = 1'b1; busy[cur_id] = 1'b1; end
            default:   wake_ready = 1'b0;
        endcase
    end

    AST_GRANT_AFTER_PF: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_kind == RSP_GRANT) |-> ($past(rsp_kind) == RSP_PF)); // R6
    AST_PF_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_ready && wake_valid) |=> (rsp_kind == RSP_PF)); // R6
    AST_UNMERGED_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_kind == RSP_PF && !merged_q) |=> (rsp_kind == RSP_NONE)); // R7
endmodule

// File: rtl/mrg_ctrl.sv
module mrg_ctrl
    import mrg_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 16,
    parameter int SW = 6,
    localparam int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid_i,
    input  logic [2:0]      req_opcode_i,
    input  logic [AW-1:0]   req_addr_i,
    input  logic [SW-1:0]   req_source_i,
    input  logic [N-1:0]    ent_valid_i,
    input  logic [N-1:0]    ent_pf_i,
    input  logic [N*AW-1:0] ent_addr_i,
    input  logic            wake_valid_i,
    input  logic [IW-1:0]   wake_id_i,
    output logic            wake_ready_o,
    output logic [1:0]      act_o,
    output logic [N-1:0]    hit_vec_o,
    output logic            rsp_valid_o,
    output logic [1:0]      rsp_kind_o,
    output logic [IW-1:0]   rsp_entry_o,
    output logic [SW-1:0]   rsp_source_o,
    output logic            train_valid_o,
    output logic [IW-1:0]   train_entry_o
);
    logic [N-1:0]  merged, busy;
    logic [IW-1:0] merge_idx, cur_id;
    logic [SW-1:0] stored_src;
    logic          grant_now;
    act_e          act;
    rsp_e          rsp_kind;

    mrg_match #(.N(N), .AW(AW)) match_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid_i), .req_opcode(req_opcode_i), .req_addr(req_addr_i),
        .ent_valid(ent_valid_i), .ent_pf(ent_pf_i), .ent_addr(ent_addr_i),
        .merged(merged), .busy(busy),
        .merge_hit(hit_vec_o), .merge_idx(merge_idx), .act(act)
    );

    mrg_entry_state #(.N(N), .SW(SW)) state_i (
        .clk(clk), .rst_n(rst_n),
        .set_en(act == ACT_MERGE), .set_idx(merge_idx), .set_src(req_source_i),
        .clr_en(grant_now), .clr_idx(cur_id),
        .rd_idx(cur_id), .merged(merged), .rd_src(stored_src)
    );

    mrg_rsp_fsm #(.N(N)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .wake_valid(wake_valid_i), .wake_id(wake_id_i), .merged(merged),
        .wake_ready(wake_ready_o), .rsp_kind(rsp_kind), .cur_id(cur_id),
        .busy(busy), .grant_now(grant_now)
    );

    assign act_o         = act;
    assign rsp_kind_o    = rsp_kind;
    assign rsp_valid_o   = (rsp_kind != RSP_NONE);
    assign rsp_entry_o   = cur_id;
    assign rsp_source_o  = grant_now ? stored_src : '0;
    assign train_valid_o = grant_now;
    assign train_entry_o = cur_id;

    AST_TRAIN_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        train_valid_o |-> (rsp_kind_o == 2'd2)); // R8
    AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_now && !(act == ACT_MERGE && merge_idx == cur_id)) |=> !merged[$past(cur_id)]); // R9
endmodule

// File: tb/mrg_ctrl_tb_top.sv
module mrg_ctrl_tb_top;
    localparam int N = 16, AW = 16, SW = 6, IW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_opcode = '0;
    logic [AW-1:0] req_addr = '0;
    logic [SW-1:0] req_source = '0;
    logic [N-1:0] ent_valid = '0, ent_pf = '0;
    logic [N*AW-1:0] ent_addr = '0;
    logic wake_valid = 1'b0;
    logic [IW-1:0] wake_id = '0;
    logic wake_ready, rsp_valid, train_valid;
    logic [1:0] act, rsp_kind;
    logic [N-1:0] hit_vec;
    logic [IW-1:0] rsp_entry, train_entry;
    logic [SW-1:0] rsp_source;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    mrg_ctrl #(.N(N), .AW(AW), .SW(SW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_opcode_i(req_opcode), .req_addr_i(req_addr),
        .req_source_i(req_source), .ent_valid_i(ent_valid), .ent_pf_i(ent_pf),
        .ent_addr_i(ent_addr), .wake_valid_i(wake_valid), .wake_id_i(wake_id),
        .wake_ready_o(wake_ready), .act_o(act), .hit_vec_o(hit_vec),
        .rsp_valid_o(rsp_valid), .rsp_kind_o(rsp_kind), .rsp_entry_o(rsp_entry),
        .rsp_source_o(rsp_source), .train_valid_o(train_valid), .train_entry_o(train_entry)
    );

    task automatic check(input string req, input longint actual, input longint expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    task automatic set_entry(input int i, input bit v, input bit pf, input logic [AW-1:0] a);
        ent_valid[i] = v;
        ent_pf[i] = pf;
        ent_addr[i*AW +: AW] = a;
    endtask

    task automatic present(input logic [2:0] opc, input logic [AW-1:0] a, input logic [SW-1:0] s);
        @(negedge clk);
        req_valid = 1'b1; req_opcode = opc; req_addr = a; req_source = s;
        #1;
    endtask

    task automatic drop_req();
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 rsp_valid", rsp_valid, 0);
        check("R10 train_valid", train_valid, 0);
        check("R10 wake_ready", wake_ready, 1);
        check("R10 act idle", act, 0);
    endtask

    task automatic t_merge();
        present(3'd6, 16'h1234, 6'd5);
        check("R1 merge act", act, 1);
        check("R2 hit vector", hit_vec, 16'h0004);
        @(negedge clk);
        check("R3 second acquire held", act, 3);
        check("R3 no hit", hit_vec, 0);
        drop_req();
    endtask

    task automatic t_nomerge();
        present(3'd4, 16'h0040, 6'd1);
        check("R4 get to prefetch entry held", act, 3);
        check("R2 hit zero", hit_vec, 0);
        present(3'd6, 16'h0080, 6'd1);
        check("R1 acquire to demand entry held", act, 3);
        present(3'd6, 16'h0999, 6'd1);
        check("R5 new address allocated", act, 2);
        drop_req();
    endtask

    task automatic t_limit();
        logic [N-1:0] sv_v, sv_p;
        logic [N*AW-1:0] sv_a;
        sv_v = ent_valid; sv_p = ent_pf; sv_a = ent_addr;
        @(negedge clk);
        for (int i = 0; i < 15; i++) set_entry(i, 1'b1, 1'b0, 16'h2000 + 16'(i));
        set_entry(15, 1'b0, 1'b0, 16'h0);
        present(3'd6, 16'h3333, 6'd2);
        check("R5 demand limit holds", act, 3);
        set_entry(14, 1'b0, 1'b0, 16'h0);
        #1;
        check("R5 below limit allocates", act, 2);
        drop_req();
        ent_valid = sv_v; ent_pf = sv_p; ent_addr = sv_a;
    endtask

    task automatic t_wake_merged();
        @(negedge clk);
        wake_valid = 1'b1; wake_id = 4'd2;
        @(negedge clk);
        wake_valid = 1'b0;
        check("R6 prefetch response", rsp_kind, 1);
        check("R6 entry", rsp_entry, 2);
        check("R8 no train yet", train_valid, 0);
        @(negedge clk);
        check("R6 grant", rsp_kind, 2);
        check("R6 grant source", rsp_source, 5);
        check("R6 grant entry", rsp_entry, 2);
        check("R8 train pulse", train_valid, 1);
        check("R8 train entry", train_entry, 2);
        @(negedge clk);
        check("R6 back to idle", wake_ready, 1);
        present(3'd6, 16'h1234, 6'd7);
        check("R9 remerge after grant", act, 1);
        drop_req();
    endtask

    task automatic t_wake_plain();
        @(negedge clk);
        wake_valid = 1'b1; wake_id = 4'd1;
        @(negedge clk);
        wake_valid = 1'b0;
        check("R7 prefetch response", rsp_kind, 1);
        @(negedge clk);
        check("R7 no grant", rsp_valid, 0);
        check("R7 no train", train_valid, 0);
    endtask

    initial begin
        #100000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        set_entry(0, 1'b1, 1'b0, 16'h0080);
        set_entry(1, 1'b1, 1'b1, 16'h0040);
        set_entry(2, 1'b1, 1'b1, 16'h1234);
        set_entry(3, 1'b1, 1'b1, 16'h0500);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_merge();
        t_nomerge();
        t_limit();
        t_wake_merged();
        t_wake_plain();
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule